// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a down-counting watchdog that sits behind a small memory-mapped register bus. Software drives it through a key register: 16-bit magic values open the configuration registers, start the timer or refresh it. Any other key closes the configuration again. The configuration consists of a 3-bit prescaler code and a 12-bit reload value. Each write to one of them becomes active only after a fixed transfer latency, and a status register shows that transfer as busy while it is in progress.

Once the timer is started, software cannot stop it. A divided clock counts the timer down from the reload value. If the count passes zero before a refresh arrives, the block raises a reset request for one cycle and reloads itself. The timeout is (reload + 1) × divider cycles of `clk`, where the divider is 4 shifted left by the prescaler code. The divider saturates at 256.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, a read at offset 0x04 returns 0, a read at offset 0x08 returns 0xFFF, a read at offset 0x0C returns 0, a read at offset 0x00 returns 0, and `rst_req` is low. Read data is combinational from `bus_addr`.
- R2: After key 0x5555 is written to offset 0x00, a write at offset 0x04 stores bits [2:0] as the prescaler code, and a write at offset 0x08 stores bits [11:0] as the reload value. Reads at the same offsets return the stored values.
- R3: Writes at offsets 0x04 and 0x08 are ignored while configuration is closed. Configuration is closed after reset, and writing any key other than 0x5555 (for example 0x0000, 0xAAAA or 0xCCCC) closes it.
- R4: The status register at 0x0C holds the prescaler-transfer busy flag in bit 0 and the reload-transfer busy flag in bit 1. All other bits read 0. A flag is set in the cycle after an accepted write, stays set for XFER_LAT cycles, and then clears.
- R5: An accepted write made while the same transfer is still busy restarts it. The flag then clears XFER_LAT cycles after the latest write.
- R6: Writing key 0xCCCC enables the timer and loads the count. `rst_req` rises exactly (reload + 1) × divider cycles after that write and is high for one cycle only.
- R7: Prescaler codes 0 to 6 select a divider of 4, 8, 16, 32, 64, 128 or 256. Code 7 also selects 256.
- R8: Writing key 0xAAAA reloads the count and restarts the divider. The next reset request then follows a full timeout after that write.
- R9: After an underflow the count reloads by itself, so reset requests repeat once per timeout.
- R10: No key write disables a running timer. In particular, key 0x0000 leaves it running.
- R11: While the timer is not enabled, `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counting logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on counter underflow |

## Verification
The bench uses the default parameters: a 12-bit count, an 8-cycle transfer latency and a divider limit of 256. With these values the busy flags can be checked on their exact last set cycle and the restart of a transfer can be observed directly. Small reload values keep each timeout to a few dozen cycles, so refreshes, periodic underflows and the disable attempt all fit in short runs. The largest cases are the saturated code 7 and the default timeout of 0xFFF at divide-by-4, which takes 16384 cycles; both are exercised after a fresh reset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int KEY_W       = 16;
    localparam int PS_LOG2_MAX = 8;
    localparam int PS_LOG2_MIN = 2;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_KICK  = 16'hAAAA;

    localparam int OFS_KEY  = 'h00;
    localparam int OFS_PSC  = 'h04;
    localparam int OFS_RLD  = 'h08;
    localparam int OFS_STAT = 'h0C;

    typedef struct packed {
        logic start;
        logic kick;
    } key_cmd_t;

    typedef struct packed {
        logic rld;
        logic psc;
    } busy_t;

    // log2 of the clock divider selected by a prescaler code, saturating
    function automatic int unsigned psc_log2(input int unsigned code);
        if (code + PS_LOG2_MIN > PS_LOG2_MAX)
            return PS_LOG2_MAX;
        return code + PS_LOG2_MIN;
    endfunction

endpackage

// File: rtl/kwd_keydec.sv
module kwd_keydec
    import kwd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              cfg_open,
    output logic              wd_en,
    output key_cmd_t          cmd
);

    logic is_open, is_start, is_kick;

    always_comb begin
        is_open  = (key_data == DATA_W'(KEY_OPEN));
        is_start = (key_data == DATA_W'(KEY_START));
        is_kick  = (key_data == DATA_W'(KEY_KICK));
        cmd.start = key_wr && is_start;
        cmd.kick  = key_wr && is_kick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_open <= 1'b0;
            wd_en    <= 1'b0;
        end else if (key_wr) begin
            cfg_open <= is_open;
            if (is_start)
                wd_en <= 1'b1;
        end
    end

endmodule

// File: rtl/kwd_xfer.sv
module kwd_xfer #(
    parameter int          W       = 12,
    parameter int          LAT     = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int LW = $clog2(LAT + 1);

    logic [LW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
            busy   <= 1'b0;
            left   <= '0;
        end else if (wr) begin
            shadow <= wdata;
            busy   <= 1'b1;
            left   <= LW'(LAT);
        end else if (busy) begin
            if (left == LW'(1)) begin
                active <= shadow;
                busy   <= 1'b0;
                left   <= '0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/kwd_core.sv
module kwd_core
    import kwd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PSC_W = 3,
    parameter int PS_W  = PS_LOG2_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_code,
    input  logic [CNT_W-1:0] reload,
    output logic             rst_req
);

    logic [PS_W-1:0]  ps_cnt;
    logic [PS_W-1:0]  ps_last;
    logic [PS_W:0]    span;
    logic [CNT_W-1:0] count;
    logic             tick;

    always_comb begin
        span    = (PS_W + 1)'(1) << psc_log2(int'(psc_code));
        ps_last = PS_W'(span - 1'b1);
        tick    = en && (ps_cnt == ps_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_cnt  <= '0;
            count   <= '1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (load) begin
                ps_cnt <= '0;
                count  <= reload;
            end else if (tick) begin
                ps_cnt <= '0;
                if (count == '0) begin
                    count   <= reload;
                    rst_req <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end else if (en) begin
                ps_cnt <= ps_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 12,
    parameter int PSC_W    = 3,
    parameter int XFER_LAT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    logic             cfg_open, wd_en;
    key_cmd_t         cmd;
    busy_t            busy;
    logic             sel_key, sel_psc, sel_rld, sel_stat;
    logic [PSC_W-1:0] psc_shadow, psc_active;
    logic [CNT_W-1:0] rld_shadow, rld_active;
    logic             psc_busy, rld_busy;

    always_comb begin
        sel_key  = (bus_addr == ADDR_W'(OFS_KEY));
        sel_psc  = (bus_addr == ADDR_W'(OFS_PSC));
        sel_rld  = (bus_addr == ADDR_W'(OFS_RLD));
        sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
        busy.psc = psc_busy;
        busy.rld = rld_busy;
    end

    kwd_keydec #(.DATA_W(DATA_W)) u_keys (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus_wr && sel_key),
        .key_data (bus_wdata),
        .cfg_open (cfg_open),
        .wd_en    (wd_en),
        .cmd      (cmd)
    );

    kwd_xfer #(.W(PSC_W), .LAT(XFER_LAT), .RST_VAL('0)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr && sel_psc && cfg_open),
        .wdata  (bus_wdata[PSC_W-1:0]),
        .shadow (psc_shadow),
        .active (psc_active),
        .busy   (psc_busy)
    );

    kwd_xfer #(.W(CNT_W), .LAT(XFER_LAT), .RST_VAL('1)) u_rld (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr && sel_rld && cfg_open),
        .wdata  (bus_wdata[CNT_W-1:0]),
        .shadow (rld_shadow),
        .active (rld_active),
        .busy   (rld_busy)
    );

    kwd_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (wd_en),
        .load     (cmd.start || cmd.kick),
        .psc_code (psc_active),
        .reload   (rld_active),
        .rst_req  (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_psc)
            bus_rdata[PSC_W-1:0] = psc_shadow;
        else if (sel_rld)
            bus_rdata[CNT_W-1:0] = rld_shadow;
        else if (sel_stat)
            bus_rdata[1:0] = busy;
        else if (sel_key)
            bus_rdata = '0;
    end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rst_req,
    input logic              wd_en,
    input logic              cfg_open,
    input logic              rld_busy,
    input logic [CNT_W-1:0]  rld_shadow
);

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_enable_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        wd_en |=> wd_en);

    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !rst_req);

    p_locked_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && bus_wr && bus_addr == ADDR_W'(8)) |=> $stable(rld_shadow));

    p_busy_set_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && bus_addr == ADDR_W'(8)) |=> rld_busy);

    p_status_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(12)) |-> (bus_rdata[DATA_W-1:2] == '0));

endmodule

bind keyed_wdog kwd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .rst_req    (rst_req),
    .wd_en      (wd_en),
    .cfg_open   (cfg_open),
    .rld_busy   (rld_busy),
    .rld_shadow (rld_shadow)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int LAT    = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rst_req;

    keyed_wdog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    logic  mon_req = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    function automatic void check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endfunction

    // monitor: pops the expected item and compares the read data
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(int'(bus_rdata), it.exp, it.tag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        bus_wr    = 1'b1;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = DATA_W'(data);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, input int exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        exp_q.push_back(it);
        bus_addr = ADDR_W'(addr);
        mon_req  = 1'b1;
        @(negedge clk);
        #1 mon_req = 1'b0;
    endtask

    // counts negedges from now until rst_req is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        @(negedge clk);
        while (!rst_req && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cycles(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        int seen;
        do_reset();

        // R1 reset state
        rd('h04, 0, "R1 prescaler reset");
        rd('h08, 'hFFF, "R1 reload reset");
        rd('h0C, 0, "R1 status reset");
        rd('h00, 0, "R1 key reads zero");
        check(int'(rst_req), 0, "R1 rst_req low");

        // R11 no request while disabled
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check(seen, 0, "R11 idle pulses");

        // R3 locked write ignored
        #1 wr('h08, 5);
        rd('h08, 'hFFF, "R3 locked reload");
        rd('h0C, 0, "R3 locked no busy");

        // R2 / R4 / R5 reload transfer with restart
        wr('h00, 'h5555);
        wr('h08, 3);
        rd('h0C, 2, "R4 reload busy set");
        cycles(3);
        rd('h0C, 2, "R4 reload busy mid");
        wr('h08, 3);
        cycles(LAT - 1);
        rd('h0C, 2, "R5 busy held after restart");
        cycles(1);
        rd('h0C, 0, "R5 busy cleared after restart");
        rd('h08, 3, "R2 reload readback");

        // R2 / R4 prescaler transfer
        wr('h04, 1);
        rd('h0C, 1, "R4 prescaler busy");
        cycles(LAT);
        rd('h0C, 0, "R4 prescaler busy clear");
        rd('h04, 1, "R2 prescaler readback");

        // R3 relock by refresh key and by 0x0000
        wr('h00, 'hAAAA);
        wr('h08, 9);
        rd('h08, 3, "R3 relock by kick key");
        wr('h00, 'h5555);
        wr('h00, 'h0000);
        wr('h04, 5);
        rd('h04, 1, "R3 relock by zero key");

        // R6 / R7 start: (3+1)*8 = 32 cycles
        wr('h00, 'hCCCC);
        wait_pulse(n);
        check(n, 32, "R6 R7 timeout div8");
        @(negedge clk);
        check(int'(rst_req), 0, "R6 one cycle pulse");
        // R9 periodic: measured from one negedge after the pulse
        wait_pulse(n);
        check(n, 30, "R9 periodic reload");

        // R8 refresh keeps it quiet, then full timeout after last kick
        #1;
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            wr('h00, 'hAAAA);
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (rst_req) seen++;
            end
            #1;
        end
        check(seen, 0, "R8 no pulse while kicked");
        wr('h00, 'hAAAA);
        wait_pulse(n);
        check(n, 32, "R8 timeout after kick");

        // R10 disable attempt
        #1 wr('h00, 'h0000);
        wait_pulse(n);
        check(int'(n < 32), 1, "R10 still running after zero key");

        // R7 code 7 saturates at 256: (1+1)*256 = 512
        do_reset();
        wr('h00, 'h5555);
        wr('h04, 7);
        wr('h08, 1);
        cycles(LAT + 1);
        rd('h0C, 0, "R4 both busy clear");
        #1 wr('h00, 'hCCCC);
        wait_pulse(n);
        check(n, 512, "R7 code7 div256");

        // R7 code 6 with reload 0: 256
        do_reset();
        wr('h00, 'h5555);
        wr('h04, 6);
        wr('h08, 0);
        cycles(LAT + 1);
        wr('h00, 'hCCCC);
        wait_pulse(n);
        check(n, 256, "R7 code6 div256 reload0");

        // R1 / R6 default timeout: 4096*4
        do_reset();
        wr('h00, 'hCCCC);
        wait_pulse(n);
        check(n, 16384, "R1 R6 default timeout");

        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule